// File: doc/BRIEF.md
# Digital Potentiometer Step Sequencer

This block sits on the host side of a three-wire digitally controlled potentiometer and turns one command into a timed sequence on the select line (active low), the direction line and the step strobe (idle high; a falling edge while selected moves the wiper one tap). A command carries a direction, a step count and a flag that asks the device to keep the new position across power loss.

Every minimum interval the device needs is given in nanoseconds as a parameter and turned into a whole number of cycles of the system clock, whose frequency is also a parameter. The sequence opens with a select/direction setup wait. It then produces the strobe pulses. It closes with one of two release forms. To save the position, select is raised while the strobe is high, followed by a long recovery. To release without saving, select is raised while the strobe is still low after the last step, followed by a short recovery.

Commands enter over a valid/ready handshake. `cmd_ready` is high only while no sequence or recovery is in progress. The host holds `cmd_valid` and the command fields steady until it sees `cmd_ready` high at a rising clock edge. While `cmd_ready` is low the command waits and is not lost. A one-cycle `done` marks the end of each command.

Top module: `potseq_host`

## Requirements
- R1: After reset `pot_sel_n`=1, `pot_step`=1, `pot_up`=0, `cmd_ready`=1 and `done`=0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. After a command that does real work is taken, `cmd_ready` is 0 from the next cycle until the cycle in which `done` is 1.
- R3: In the cycle after a command is taken, `pot_sel_n` falls and `pot_up` takes the command direction while `pot_step` stays 1. The first strobe fall follows after the larger of the select setup and direction setup intervals.
- R4: Each step holds `pot_step` low for the larger of the low-width interval and (period − high-width), then high for the high-width interval. The strobe never falls while `pot_sel_n` is 1.
- R5: A step count above MAX_STEPS (default 99) gives exactly MAX_STEPS strobe falling edges.
- R6: With the store flag set, the strobe stays high after the last step for the larger of the high-width and strobe-to-deselect intervals. `pot_sel_n` then rises with `pot_step` high and stays high for the store recovery interval before `done`.
- R7: With the store flag clear, the last low phase lasts the larger of the low-width and strobe-to-deselect intervals. `pot_sel_n` then rises with `pot_step` still 0. The strobe stays low for the plain recovery interval, then high for the direction-hold interval, before `done`.
- R8: Zero steps with the store flag set gives the setup wait, the post-step wait and the store release, with no strobe falling edge.
- R9: Zero steps with the store flag clear leaves `pot_sel_n`, `pot_step` and `pot_up` unchanged. `done` is 1 in the next cycle and `cmd_ready` stays 1.
- R10: `done` is 1 for one cycle, and only when `cmd_ready` is 1. A command may be taken in that same cycle.
- R11: Each interval is ceil(ns × CLK_HZ / 1e9) cycles, and at least 1 cycle.
- R12: `pot_up` changes only while `pot_sel_n` is 1, and at least the direction-hold interval after the strobe last rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_up | input | 1 | Direction: 1 moves the wiper up |
| cmd_steps | input | STEP_W | Requested step count |
| cmd_store | input | 1 | 1 = save the position on release |
| pot_sel_n | output | 1 | Device select, active low |
| pot_step | output | 1 | Step strobe, falling edge moves the wiper |
| pot_up | output | 1 | Direction line to the device |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The end-of-command pulse and the acceptance of the next command can fall in the same cycle. The bench provokes this by holding `cmd_valid` high through a busy sequence, so the waiting command is taken exactly where `done` is 1. A no-work command is also issued right after another one, so its own `done` lands next to a handshake. A behavioural model built from the requirement intervals predicts every line in every cycle. The bench judges both that the new sequence begins in the following cycle and that the pulse is not stretched or lost.

// File: rtl/potseq_pkg.sv
package potseq_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_SETUP,
    PS_LOW,
    PS_HIGH,
    PS_REC_LO,
    PS_REC_HI
  } pstate_e;

  // Whole clock cycles covering a nanosecond interval, rounded up, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned hz);
    longint unsigned prod;
    longint unsigned q;
    prod = 64'(ns) * 64'(hz) + 64'd999_999_999;
    q    = prod / 64'd1_000_000_000;
    if (q == 64'd0) q = 64'd1;
    return 32'(q);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/potseq_timer.sv
module potseq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/potseq_cmd.sv
module potseq_cmd #(
  parameter int unsigned STEP_W    = 8,
  parameter int unsigned MAX_STEPS = 99,
  parameter int unsigned SL_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              cmd_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_store,
  output logic [SL_W-1:0]   steps_clamped,
  output logic              noop,
  output logic              dir_q,
  output logic              store_q
);

  localparam longint unsigned FULL = (64'd1 << STEP_W) - 64'd1;

  generate
    if (FULL <= 64'(MAX_STEPS)) begin : g_direct
      assign steps_clamped = SL_W'(cmd_steps);
    end else begin : g_clamp
      localparam logic [STEP_W-1:0] LIM = STEP_W'(MAX_STEPS);
      assign steps_clamped = (cmd_steps > LIM) ? SL_W'(MAX_STEPS) : SL_W'(cmd_steps);
    end
  endgenerate

  assign noop = (cmd_steps == '0) && !cmd_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      store_q <= 1'b0;
    end else if (take) begin
      dir_q   <= cmd_up;
      store_q <= cmd_store;
    end
  end

endmodule

// File: rtl/potseq_fsm.sv
module potseq_fsm
  import potseq_pkg::*;
#(
  parameter int unsigned SL_W      = 7,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned N_SETUP   = 1,
  parameter int unsigned N_LO      = 1,
  parameter int unsigned N_HI      = 1,
  parameter int unsigned N_TAIL_LO = 1,
  parameter int unsigned N_TAIL_HI = 1,
  parameter int unsigned N_ST      = 1,
  parameter int unsigned N_NS      = 1,
  parameter int unsigned N_DH      = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             noop,
  input  logic [SL_W-1:0]  steps_in,
  input  logic             store,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ready,
  output logic             take,
  output logic             sel_n,
  output logic             step,
  output logic             done
);

  localparam logic [CNT_W-1:0] V_SETUP   = CNT_W'(N_SETUP - 1);
  localparam logic [CNT_W-1:0] V_LO      = CNT_W'(N_LO - 1);
  localparam logic [CNT_W-1:0] V_HI      = CNT_W'(N_HI - 1);
  localparam logic [CNT_W-1:0] V_TAIL_LO = CNT_W'(N_TAIL_LO - 1);
  localparam logic [CNT_W-1:0] V_TAIL_HI = CNT_W'(N_TAIL_HI - 1);
  localparam logic [CNT_W-1:0] V_ST      = CNT_W'(N_ST - 1);
  localparam logic [CNT_W-1:0] V_NS      = CNT_W'(N_NS - 1);
  localparam logic [CNT_W-1:0] V_DH      = CNT_W'(N_DH - 1);

  pstate_e          state_q, state_d;
  logic [SL_W-1:0]  steps_q, steps_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] low_val;

  // The last low phase of a plain release also covers strobe-to-deselect.
  assign low_val = ((steps_q == SL_W'(1)) && !store) ? V_TAIL_LO : V_LO;

  always_comb begin
    state_d  = state_q;
    steps_d  = steps_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      PS_IDLE: begin
        if (cmd_valid) begin
          if (noop) begin
            done_d = 1'b1;
          end else begin
            state_d  = PS_SETUP;
            steps_d  = steps_in;
            tmr_load = 1'b1;
            tmr_val  = V_SETUP;
          end
        end
      end
      PS_SETUP: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (steps_q == '0) begin
            state_d = PS_HIGH;
            tmr_val = V_TAIL_HI;
          end else begin
            state_d = PS_LOW;
            steps_d = steps_q - 1'b1;
            tmr_val = low_val;
          end
        end
      end
      PS_LOW: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if ((steps_q == '0) && !store) begin
            state_d = PS_REC_LO;
            tmr_val = V_NS;
          end else begin
            state_d = PS_HIGH;
            tmr_val = (steps_q == '0) ? V_TAIL_HI : V_HI;
          end
        end
      end
      PS_HIGH: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (steps_q == '0) begin
            state_d = PS_REC_HI;
            tmr_val = V_ST;
          end else begin
            state_d = PS_LOW;
            steps_d = steps_q - 1'b1;
            tmr_val = low_val;
          end
        end
      end
      PS_REC_LO: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          state_d  = PS_REC_HI;
          tmr_val  = V_DH;
        end
      end
      PS_REC_HI: begin
        if (tmr_done) begin
          state_d = PS_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      steps_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      steps_q <= steps_d;
      done_q  <= done_d;
    end
  end

  assign ready = (state_q == PS_IDLE);
  assign take  = ready && cmd_valid && !noop;
  assign sel_n = (state_q == PS_IDLE) || (state_q == PS_REC_LO) || (state_q == PS_REC_HI);
  assign step  = !((state_q == PS_LOW) || (state_q == PS_REC_LO));
  assign done  = done_q;

endmodule

// File: rtl/potseq_host.sv
module potseq_host
  import potseq_pkg::*;
#(
  parameter int unsigned CLK_HZ             = 100_000_000,
  parameter int unsigned STEP_W             = 8,
  parameter int unsigned MAX_STEPS          = 99,
  parameter int unsigned T_SEL_SETUP_NS     = 100,
  parameter int unsigned T_DIR_SETUP_NS     = 2900,
  parameter int unsigned T_DIR_HOLD_NS      = 100,
  parameter int unsigned T_LOW_NS           = 1000,
  parameter int unsigned T_HIGH_NS          = 1000,
  parameter int unsigned T_PERIOD_NS        = 2000,
  parameter int unsigned T_IDLE_TO_DESEL_NS = 1000,
  parameter int unsigned T_REC_STORE_NS     = 20_000_000,
  parameter int unsigned T_REC_PLAIN_NS     = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_store,
  output logic              pot_sel_n,
  output logic              pot_step,
  output logic              pot_up,
  output logic              done
);

  localparam int unsigned C_SS  = ns_to_cyc(T_SEL_SETUP_NS, CLK_HZ);
  localparam int unsigned C_DS  = ns_to_cyc(T_DIR_SETUP_NS, CLK_HZ);
  localparam int unsigned C_DH  = ns_to_cyc(T_DIR_HOLD_NS, CLK_HZ);
  localparam int unsigned C_LO  = ns_to_cyc(T_LOW_NS, CLK_HZ);
  localparam int unsigned C_HI  = ns_to_cyc(T_HIGH_NS, CLK_HZ);
  localparam int unsigned C_PER = ns_to_cyc(T_PERIOD_NS, CLK_HZ);
  localparam int unsigned C_IC  = ns_to_cyc(T_IDLE_TO_DESEL_NS, CLK_HZ);
  localparam int unsigned C_ST  = ns_to_cyc(T_REC_STORE_NS, CLK_HZ);
  localparam int unsigned C_NS  = ns_to_cyc(T_REC_PLAIN_NS, CLK_HZ);

  localparam int unsigned N_SETUP   = umax(C_SS, C_DS);
  localparam int unsigned N_LO      = umax(C_LO, (C_PER > C_HI) ? (C_PER - C_HI) : 1);
  localparam int unsigned N_HI      = C_HI;
  localparam int unsigned N_TAIL_LO = umax(N_LO, C_IC);
  localparam int unsigned N_TAIL_HI = umax(N_HI, C_IC);
  localparam int unsigned N_MAXC    = umax(umax(umax(N_SETUP, N_TAIL_LO), umax(N_TAIL_HI, C_ST)),
                                           umax(C_NS, C_DH));
  localparam int unsigned CNT_W     = $clog2(N_MAXC + 1);
  localparam int unsigned SL_W      = $clog2(MAX_STEPS + 1);

  logic [SL_W-1:0]  steps_clamped;
  logic             noop;
  logic             take;
  logic             store_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  potseq_cmd #(
    .STEP_W    (STEP_W),
    .MAX_STEPS (MAX_STEPS),
    .SL_W      (SL_W)
  ) u_cmd (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .cmd_up        (cmd_up),
    .cmd_steps     (cmd_steps),
    .cmd_store     (cmd_store),
    .steps_clamped (steps_clamped),
    .noop          (noop),
    .dir_q         (pot_up),
    .store_q       (store_q)
  );

  potseq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  potseq_fsm #(
    .SL_W      (SL_W),
    .CNT_W     (CNT_W),
    .N_SETUP   (N_SETUP),
    .N_LO      (N_LO),
    .N_HI      (N_HI),
    .N_TAIL_LO (N_TAIL_LO),
    .N_TAIL_HI (N_TAIL_HI),
    .N_ST      (C_ST),
    .N_NS      (C_NS),
    .N_DH      (C_DH)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .noop      (noop),
    .steps_in  (steps_clamped),
    .store     (store_q),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .ready     (cmd_ready),
    .take      (take),
    .sel_n     (pot_sel_n),
    .step      (pot_step),
    .done      (done)
  );

endmodule

// File: rtl/potseq_host_chk.sv
module potseq_host_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic cmd_real,
  input logic pot_sel_n,
  input logic pot_step,
  input logic pot_up,
  input logic done
);

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_real) |=> !cmd_ready);

  // R10
  done_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R3
  sel_fall_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pot_sel_n) |-> pot_step);

  // R4
  step_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pot_step) |-> (!pot_sel_n && $past(!pot_sel_n)));

  // R12
  dir_stable_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pot_sel_n && $past(!pot_sel_n)) |-> $stable(pot_up));

  // R6
  sel_rise_strobe_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pot_sel_n) |-> $stable(pot_step));

endmodule

bind potseq_host potseq_host_chk u_potseq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_real  ((cmd_steps != '0) || cmd_store),
  .pot_sel_n (pot_sel_n),
  .pot_step  (pot_step),
  .pot_up    (pot_up),
  .done      (done)
);

// File: tb/potseq_host_test.sv
module potseq_host_test;

  localparam int unsigned HZ = 2_000_000;
  localparam int PER_NS = 500;

  function automatic int cyc(int ns);
    int c;
    c = (ns + PER_NS - 1) / PER_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic       cmd_up = 1'b0;
  logic [7:0] cmd_steps = '0;
  logic       cmd_store = 1'b0;
  logic       pot_sel_n, pot_step, pot_up, done;

  potseq_host #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_up(cmd_up), .cmd_steps(cmd_steps), .cmd_store(cmd_store),
    .pot_sel_n(pot_sel_n), .pot_step(pot_step), .pot_up(pot_up), .done(done)
  );

  int checks = 0;
  int fails = 0;
  int e_setup, e_lo, e_hi, e_tlo, e_thi, e_st, e_ns, e_dh;
  bit [4:0] vq[$];
  string tq[$];
  bit mdir = 1'b0;
  int cycn = 0;
  int falls = 0;
  int sel_fall_at = -1;
  int fall_at = -1;
  bit prev_step = 1'b1;
  bit prev_sel = 1'b1;
  bit acc_done = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic add(int n, bit s, bit st, bit r, bit d, string tag);
    repeat (n) begin
      vq.push_back({s, st, mdir, r, d});
      tq.push_back(tag);
    end
  endtask

  task automatic model(bit up, int steps, bit st);
    int k;
    k = (steps > 99) ? 99 : steps;
    if (k == 0 && !st) begin
      add(1, 1, 1, 1, 1, "R9");
    end else begin
      mdir = up;
      add(e_setup, 0, 1, 0, 0, "R3");
      if (k == 0) add(e_thi, 0, 1, 0, 0, "R8");
      for (int i = 0; i < k; i++) begin
        if (i == k - 1 && !st) begin
          add(e_tlo, 0, 0, 0, 0, "R7");
          add(e_ns, 1, 0, 0, 0, "R7");
          add(e_dh, 1, 1, 0, 0, "R7");
        end else if (i == k - 1) begin
          add(e_lo, 0, 0, 0, 0, "R4");
          add(e_thi, 0, 1, 0, 0, "R6");
        end else begin
          add(e_lo, 0, 0, 0, 0, "R4");
          add(e_hi, 0, 1, 0, 0, "R4");
        end
      end
      if (st) add(e_st, 1, 1, 0, 0, "R6");
      add(1, 1, 1, 1, 1, "R10");
    end
  endtask

  task automatic compare();
    bit [4:0] e;
    bit [4:0] a;
    string tag;
    if (vq.size() != 0) begin
      e = vq.pop_front();
      tag = tq.pop_front();
    end else begin
      e = {1'b1, 1'b1, mdir, 1'b1, 1'b0};
      tag = "R2";
    end
    a = {pot_sel_n, pot_step, pot_up, cmd_ready, done};
    chk(a[4:3] == e[4:3], tag, "sel_n/step", int'(a[4:3]), int'(e[4:3]));
    chk(a[2] == e[2], "R12", "dir", int'(a[2]), int'(e[2]));
    chk(a[1] == e[1], "R2", "ready", int'(a[1]), int'(e[1]));
    chk(a[0] == e[0], "R10", "done", int'(a[0]), int'(e[0]));
    if (prev_step && !pot_step && !pot_sel_n) begin
      falls++;
      if (fall_at < 0) fall_at = cycn;
    end
    if (prev_sel && !pot_sel_n && sel_fall_at < 0) sel_fall_at = cycn;
    prev_step = pot_step;
    prev_sel = pot_sel_n;
  endtask

  task automatic tick(output bit acc);
    acc = cmd_valid && cmd_ready;
    if (acc) begin
      acc_done = done;
      model(cmd_up, int'(cmd_steps), cmd_store);
    end
    @(posedge clk);
    @(negedge clk);
    cycn++;
    compare();
  endtask

  task automatic send(bit up, int steps, bit st);
    bit a;
    cmd_up = up;
    cmd_steps = 8'(steps);
    cmd_store = st;
    cmd_valid = 1'b1;
    do tick(a); while (!a);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    bit a;
    while (vq.size() != 0) tick(a);
    tick(a);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int f0;
    e_setup = imax(cyc(100), cyc(2900));
    e_lo    = imax(cyc(1000), imax(cyc(2000) - cyc(1000), 1));
    e_hi    = cyc(1000);
    e_tlo   = imax(e_lo, cyc(1000));
    e_thi   = imax(e_hi, cyc(1000));
    e_st    = cyc(20_000_000);
    e_ns    = cyc(100);
    e_dh    = cyc(100);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(pot_sel_n == 1'b1, "R1", "sel_n", int'(pot_sel_n), 1);
    chk(pot_step == 1'b1, "R1", "step", int'(pot_step), 1);
    chk(pot_up == 1'b0, "R1", "dir", int'(pot_up), 0);
    chk(cmd_ready == 1'b1, "R1", "ready", int'(cmd_ready), 1);
    chk(done == 1'b0, "R1", "done", int'(done), 0);

    // R11 setup interval rounding, R4 step shape, R7 plain release
    sel_fall_at = -1;
    fall_at = -1;
    send(1'b1, 3, 1'b0);
    wait_idle();
    chk(fall_at - sel_fall_at == 6, "R11", "setup cycles", fall_at - sel_fall_at, 6);

    // R10 command waiting through a busy sequence is taken in the done cycle
    send(1'b0, 2, 1'b0);
    send(1'b1, 1, 1'b0);
    chk(acc_done == 1'b1, "R10", "take in done cycle", int'(acc_done), 1);
    wait_idle();

    // R9 no-work commands, back to back
    send(1'b0, 0, 1'b0);
    send(1'b0, 0, 1'b0);
    wait_idle();
    chk(pot_up == 1'b1, "R9", "dir kept", int'(pot_up), 1);

    // R5 clamp
    f0 = falls;
    send(1'b1, 150, 1'b0);
    wait_idle();
    chk(falls - f0 == 99, "R5", "strobe falls", falls - f0, 99);

    // R6 store with one step
    f0 = falls;
    send(1'b0, 1, 1'b1);
    wait_idle();
    chk(falls - f0 == 1, "R6", "strobe falls", falls - f0, 1);

    // R8 store with zero steps
    f0 = falls;
    send(1'b1, 0, 1'b1);
    wait_idle();
    chk(falls - f0 == 0, "R8", "strobe falls", falls - f0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule